// File: doc/BRIEF.md
# Multiple-Word Register Transfer Sequencer

This block moves a run of consecutive 32-bit words between memory and the general register file for the two multiple-word instructions. The caller presents a start strobe with the primary opcode, the first register number, the base-register field with the value already read from that register, and a 16-bit displacement. The sequencer then visits every register from the first one up to the highest (register 31), one word per register. It issues one memory request at a time and steps the address by four bytes between words.

For a load, each returned word is zero-extended and written into the register being visited. For a store, the low 32 bits of that register are read and sent to memory. A base field of zero means a zero base, not the contents of register 0. While a sequence runs, `busy` is high. A single-cycle `done` pulse marks the end.

Top module: `mwx_sequencer`

## Requirements
- R1: After reset, `busy`, `done`, `mem_req_valid` and `rf_we` are all low.
- R2: A `start` seen while idle begins a load sequence when `opcode` is 46 and a store sequence when it is 47. A `start` with any other opcode, or a `start` seen while busy, is ignored: it produces no request and no register write, and it does not change the sequence already running.
- R3: The first request address is the base plus `disp` sign-extended from 16 bits. The base is zero when `base_field` is 0, and `base_value` otherwise.
- R4: Requests visit registers `first_reg`, `first_reg`+1, and so on up to 31, one word each. When `first_reg` is 31, exactly one word is transferred.
- R5: Each request address is 4 greater than the previous one in the same sequence.
- R6: For a load, the register being visited is written in the cycle its response arrives (`rf_we` high, `rf_wr_idx` set to that register). The written value is the 32-bit response data with the upper 32 bits zero.
- R7: For a store, `mem_req_write` is 1 and `mem_req_wdata` is the low word of the register being visited. For a load, `mem_req_write` is 0.
- R8: At most one request is outstanding. No new request is raised until the response to the previous one arrives. While `mem_req_valid` is high and `mem_req_ready` is low, the request's address and direction stay stable.
- R9: `done` is high for exactly one cycle, in the cycle after the last response. `busy` is high from the cycle after an accepted start through that `done` cycle, and low after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a sequence (taken only when idle) |
| opcode | input | 6 | Primary opcode: 46 load, 47 store |
| first_reg | input | 5 | First register number of the run |
| base_field | input | 5 | Base register number (0 means zero base) |
| base_value | input | 64 | Contents of the base register |
| disp | input | 16 | Signed displacement |
| rf_rd_idx | output | 5 | Register-file read index |
| rf_rd_word | input | 32 | Low word of the register selected by `rf_rd_idx` |
| rf_we | output | 1 | Register-file write enable |
| rf_wr_idx | output | 5 | Register-file write index |
| rf_wr_data | output | 64 | Register-file write data |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request ready |
| mem_req_write | output | 1 | 1 for a store request, 0 for a load request |
| mem_req_addr | output | 64 | Request byte address |
| mem_req_wdata | output | 32 | Store data |
| mem_rsp_valid | input | 1 | Memory response valid |
| mem_rsp_rdata | input | 32 | Load response data |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bound assertions check on every cycle that only one request is ever in flight and that a stalled request holds its address and direction. They also check that consecutive addresses in a sequence differ by four, that register writes occur only with a response and carry zero upper bits, that nothing moves while idle, and that `done` is a single pulse inside `busy`. Only the directed scenarios can show the rest: the right starting address for a zero or nonzero base field and for a negative displacement, the exact register range and word count, the values landing in the register model, and the store data reaching memory. They also show that illegal opcodes and starts issued mid-sequence leave everything untouched.

// File: rtl/mwx_pkg.sv
// Shared definitions for the multiple-word transfer sequencer.
// Assumes a 6-bit primary opcode field.
package mwx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_WAIT = 2'd2,
        ST_FIN  = 2'd3
    } mwx_state_e;

    localparam logic [5:0] OPC_LOAD_MULTI  = 6'd46;
    localparam logic [5:0] OPC_STORE_MULTI = 6'd47;
endpackage

// File: rtl/mwx_addr_gen.sv
// Effective-address generator. On load_en it forms base + sign-extended
// displacement, with a zero base when the base field is 0. On step_en it
// advances by one word. Assumes load_en and step_en are never high together.
module mwx_addr_gen #(
    parameter int XLEN       = 64,
    parameter int DISP_W     = 16,
    parameter int IDX_W      = 5,
    parameter int WORD_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic              step_en,
    input  logic [IDX_W-1:0]  base_field,
    input  logic [XLEN-1:0]   base_value,
    input  logic [DISP_W-1:0] disp,
    output logic [XLEN-1:0]   addr
);
    localparam logic [XLEN-1:0] STEP = XLEN'(WORD_BYTES);

    logic [XLEN-1:0] base_sel;
    logic [XLEN-1:0] disp_ext;

    // Choose the base and sign-extend the displacement.
    always_comb begin
        base_sel = (base_field == '0) ? '0 : base_value;
        disp_ext = {{(XLEN-DISP_W){disp[DISP_W-1]}}, disp};
    end

    // Hold the current request address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr <= '0;
        end else if (load_en) begin
            addr <= base_sel + disp_ext;
        end else if (step_en) begin
            addr <= addr + STEP;
        end
    end
endmodule

// File: rtl/mwx_ctrl.sv
// Sequencing control. Accepts a start for the two multiple-word opcodes
// while idle, walks the register index up to the last register, keeps one
// memory request in flight, and ends with a done state.
// Assumes the responder returns exactly one response per accepted request.
module mwx_ctrl
    import mwx_pkg::*;
#(
    parameter int NREG  = 32,
    parameter int IDX_W = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [5:0]       opcode,
    input  logic [IDX_W-1:0] first_reg,
    input  logic             req_ready,
    input  logic             rsp_valid,
    output logic             launch,
    output logic             step,
    output logic             rsp_take,
    output logic             is_store,
    output logic [IDX_W-1:0] idx,
    output logic             req_valid,
    output logic             busy,
    output logic             done
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NREG - 1);

    mwx_state_e state;
    logic       opc_ok;
    logic       at_last;

    // Decode the start condition and the per-word handshakes.
    always_comb begin
        opc_ok    = (opcode == OPC_LOAD_MULTI) || (opcode == OPC_STORE_MULTI);
        launch    = (state == ST_IDLE) && start && opc_ok;
        rsp_take  = (state == ST_WAIT) && rsp_valid;
        at_last   = (idx == LAST_IDX);
        step      = rsp_take && !at_last;
        req_valid = (state == ST_REQ);
        busy      = (state != ST_IDLE);
        done      = (state == ST_FIN);
    end

    // Advance the sequencing state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE: if (launch)    state <= ST_REQ;
                ST_REQ:  if (req_ready) state <= ST_WAIT;
                ST_WAIT: if (rsp_valid) state <= at_last ? ST_FIN : ST_REQ;
                default:                state <= ST_IDLE;
            endcase
        end
    end

    // Track the register index and the transfer direction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx      <= '0;
            is_store <= 1'b0;
        end else if (launch) begin
            idx      <= first_reg;
            is_store <= (opcode == OPC_STORE_MULTI);
        end else if (step) begin
            idx      <= idx + 1'b1;
        end
    end
endmodule

// File: rtl/mwx_sequencer.sv
// Top of the multiple-word transfer sequencer. Connects the control and
// address generator to a register-file port and a valid/ready memory port.
// Assumes a register-file read whose data is valid in the same cycle
// (low word only), and memory responses arriving after acceptance.
module mwx_sequencer #(
    parameter int XLEN   = 64,
    parameter int WORD_W = 32,
    parameter int NREG   = 32,
    parameter int DISP_W = 16,
    parameter int IDX_W  = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [5:0]        opcode,
    input  logic [IDX_W-1:0]  first_reg,
    input  logic [IDX_W-1:0]  base_field,
    input  logic [XLEN-1:0]   base_value,
    input  logic [DISP_W-1:0] disp,
    output logic [IDX_W-1:0]  rf_rd_idx,
    input  logic [WORD_W-1:0] rf_rd_word,
    output logic              rf_we,
    output logic [IDX_W-1:0]  rf_wr_idx,
    output logic [XLEN-1:0]   rf_wr_data,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic              mem_req_write,
    output logic [XLEN-1:0]   mem_req_addr,
    output logic [WORD_W-1:0] mem_req_wdata,
    input  logic              mem_rsp_valid,
    input  logic [WORD_W-1:0] mem_rsp_rdata,
    output logic              busy,
    output logic              done
);
    localparam int WORD_BYTES = WORD_W / 8;

    logic             launch;
    logic             step;
    logic             rsp_take;
    logic             is_store;
    logic [IDX_W-1:0] idx;

    mwx_ctrl #(
        .NREG  (NREG),
        .IDX_W (IDX_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .opcode    (opcode),
        .first_reg (first_reg),
        .req_ready (mem_req_ready),
        .rsp_valid (mem_rsp_valid),
        .launch    (launch),
        .step      (step),
        .rsp_take  (rsp_take),
        .is_store  (is_store),
        .idx       (idx),
        .req_valid (mem_req_valid),
        .busy      (busy),
        .done      (done)
    );

    mwx_addr_gen #(
        .XLEN       (XLEN),
        .DISP_W     (DISP_W),
        .IDX_W      (IDX_W),
        .WORD_BYTES (WORD_BYTES)
    ) u_addr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_en    (launch),
        .step_en    (step),
        .base_field (base_field),
        .base_value (base_value),
        .disp       (disp),
        .addr       (mem_req_addr)
    );

    // Route the visited register to both ports and zero-extend load data.
    always_comb begin
        rf_rd_idx     = idx;
        rf_wr_idx     = idx;
        rf_we         = rsp_take && !is_store;
        rf_wr_data    = {{(XLEN-WORD_W){1'b0}}, mem_rsp_rdata};
        mem_req_write = is_store;
        mem_req_wdata = rf_rd_word;
    end
endmodule

// File: rtl/mwx_checker.sv
// Cycle-level properties of the sequencer, attached by bind.
// Assumes the same parameters as the sequencer it is bound to.
module mwx_checker #(
    parameter int XLEN   = 64,
    parameter int WORD_W = 32,
    parameter int IDX_W  = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rf_we,
    input logic [XLEN-1:0]   rf_wr_data,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic              mem_req_write,
    input logic [XLEN-1:0]   mem_req_addr,
    input logic              mem_rsp_valid,
    input logic              busy,
    input logic              done
);
    logic            hs;
    logic            outstanding;
    logic            have_prev;
    logic [XLEN-1:0] last_addr;

    assign hs = mem_req_valid && mem_req_ready;

    // Track the request in flight and the previous address of the sequence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            outstanding <= 1'b0;
            have_prev   <= 1'b0;
            last_addr   <= '0;
        end else begin
            if (hs)                 outstanding <= 1'b1;
            else if (mem_rsp_valid) outstanding <= 1'b0;
            if (done)    have_prev <= 1'b0;
            else if (hs) have_prev <= 1'b1;
            if (hs) last_addr <= mem_req_addr;
        end
    end

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> !busy && !done && !mem_req_valid && !rf_we); // R1

    AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req_valid && !rf_we); // R2

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (hs && have_prev) |-> mem_req_addr == last_addr + XLEN'(WORD_W / 8)); // R5

    AST_WE_WITH_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> mem_rsp_valid && !mem_req_write); // R6

    AST_WE_ZERO_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> rf_wr_data[XLEN-1:WORD_W] == '0); // R6

    AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        outstanding |-> !mem_req_valid); // R8

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=>
            mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write)); // R8

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9

    AST_DONE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy); // R9

    AST_BUSY_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy); // R9
endmodule

bind mwx_sequencer mwx_checker #(
    .XLEN   (XLEN),
    .WORD_W (WORD_W),
    .IDX_W  (IDX_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .rf_we         (rf_we),
    .rf_wr_data    (rf_wr_data),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_write (mem_req_write),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .busy          (busy),
    .done          (done)
);

// File: tb/sim_mwx_sequencer.sv
// Directed bench for the multiple-word transfer sequencer.
module sim_mwx_sequencer;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [5:0]  opcode = '0;
    logic [4:0]  first_reg = '0;
    logic [4:0]  base_field = '0;
    logic [63:0] base_value = '0;
    logic [15:0] disp = '0;
    logic [4:0]  rf_rd_idx;
    logic [31:0] rf_rd_word;
    logic        rf_we;
    logic [4:0]  rf_wr_idx;
    logic [63:0] rf_wr_data;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic        mem_req_write;
    logic [63:0] mem_req_addr;
    logic [31:0] mem_req_wdata;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_rdata = '0;
    logic        busy;
    logic        done;

    int nchecks = 0;
    int nerrors = 0;

    logic [63:0] regs [32];
    logic [63:0] log_addr [32];
    logic        log_wr [32];
    logic [31:0] log_wdata [32];
    int          nlog = 0;
    int          stall_cfg = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    mwx_sequencer u0 (
        .clk (clk), .rst_n (rst_n), .start (start), .opcode (opcode),
        .first_reg (first_reg), .base_field (base_field),
        .base_value (base_value), .disp (disp),
        .rf_rd_idx (rf_rd_idx), .rf_rd_word (rf_rd_word),
        .rf_we (rf_we), .rf_wr_idx (rf_wr_idx), .rf_wr_data (rf_wr_data),
        .mem_req_valid (mem_req_valid), .mem_req_ready (mem_req_ready),
        .mem_req_write (mem_req_write), .mem_req_addr (mem_req_addr),
        .mem_req_wdata (mem_req_wdata), .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_rdata (mem_rsp_rdata), .busy (busy), .done (done)
    );

    assign rf_rd_word = regs[rf_rd_idx][31:0];

    function automatic logic [31:0] pat(input logic [63:0] a);
        return a[31:0] ^ 32'h5A5A_C3C3;
    endfunction

    // Register-file model write port.
    always @(posedge clk) begin
        if (rf_we) regs[rf_wr_idx] <= rf_wr_data;
    end

    // Memory responder: logs accepted requests and answers one cycle later.
    initial begin
        logic        pend = 1'b0;
        logic [63:0] pend_addr = '0;
        int          hold = 0;
        forever begin
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            mem_req_ready = 1'b0;
            if (pend) begin
                mem_rsp_valid = 1'b1;
                mem_rsp_rdata = pat(pend_addr);
                pend = 1'b0;
            end else if (mem_req_valid) begin
                if (hold > 0) begin
                    hold--;
                end else begin
                    mem_req_ready = 1'b1;
                    if (nlog < 32) begin
                        log_addr[nlog]  = mem_req_addr;
                        log_wr[nlog]    = mem_req_write;
                        log_wdata[nlog] = mem_req_wdata;
                    end
                    nlog++;
                    pend = 1'b1;
                    pend_addr = mem_req_addr;
                    hold = stall_cfg;
                end
            end
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        nchecks++;
        if (act !== exp) begin
            nerrors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Pulse start for one cycle, then wait for done while watching busy/done.
    task automatic run_op(input logic [5:0] opc, input logic [4:0] fr,
                          input logic [4:0] bf, input logic [63:0] bv,
                          input logic [15:0] d, input bit poke_mid);
        int cyc = 0;
        bit busy_ok = 1'b1;
        nlog = 0;
        @(negedge clk);
        opcode = opc; first_reg = fr; base_field = bf; base_value = bv; disp = d;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!done && cyc < 1000) begin
            if (!busy) busy_ok = 1'b0;
            if (poke_mid && cyc == 3) begin
                opcode = 6'd46; first_reg = 5'd0; base_field = 5'd0; disp = 16'h7000;
                start = 1'b1;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            cyc++;
        end
        start = 1'b0;
        chk("R9", "busy held during sequence", 64'(busy_ok), 64'd1);
        chk("R9", "done seen", 64'(done), 64'd1);
        chk("R9", "busy during done", 64'(busy), 64'd1);
        @(negedge clk);
        chk("R9", "done single cycle", 64'(done), 64'd0);
        chk("R9", "busy low after done", 64'(busy), 64'd0);
    endtask

    task automatic check_log(input string req, input int first,
                             input logic [63:0] addr0, input logic wr);
        chk(req, "word count", 64'(nlog), 64'(32 - first));
        for (int k = 0; k < 32 - first; k++) begin
            chk("R5", "request address", log_addr[k], addr0 + 64'(4 * k));
            chk("R7", "request direction", 64'(log_wr[k]), 64'(wr));
        end
    endtask

    task automatic t_reset;
        chk("R1", "busy", 64'(busy), 64'd0);
        chk("R1", "done", 64'(done), 64'd0);
        chk("R1", "req_valid", 64'(mem_req_valid), 64'd0);
        chk("R1", "rf_we", 64'(rf_we), 64'd0);
    endtask

    task automatic t_load_nonzero_base;
        stall_cfg = 0;
        for (int r = 0; r < 32; r++) regs[r] = {32'hFFFF_FFFF, 27'd0, 5'(r)};
        run_op(6'd46, 5'd28, 5'd3, 64'h1000, 16'h0008, 1'b0);
        check_log("R4", 28, 64'h1008, 1'b0);
        chk("R3", "first address", log_addr[0], 64'h1008);
        for (int r = 28; r < 32; r++)
            chk("R6", "loaded register", regs[r], {32'd0, pat(64'h1008 + 64'(4 * (r - 28)))});
        chk("R4", "register below range untouched", regs[27], {32'hFFFF_FFFF, 32'd27});
    endtask

    task automatic t_store_zero_base;
        stall_cfg = 0;
        for (int r = 29; r < 32; r++) regs[r] = {32'hABCD_0000, 32'h1111_0000 + 32'(r)};
        run_op(6'd47, 5'd29, 5'd0, 64'hDEAD_0000, 16'h0040, 1'b0);
        check_log("R4", 29, 64'h40, 1'b1);
        chk("R3", "zero base first address", log_addr[0], 64'h40);
        for (int k = 0; k < 3; k++)
            chk("R7", "store data", 64'(log_wdata[k]), 64'(32'h1111_0000 + 32'(29 + k)));
        chk("R7", "store leaves registers", regs[30], {32'hABCD_0000, 32'h1111_001E});
    endtask

    task automatic t_single_word_negative_disp;
        stall_cfg = 0;
        run_op(6'd46, 5'd31, 5'd5, 64'h2000, 16'hFFF0, 1'b0);
        chk("R4", "single word count", 64'(nlog), 64'd1);
        chk("R3", "negative displacement", log_addr[0], 64'h1FF0);
        chk("R6", "register 31 loaded", regs[31], {32'd0, pat(64'h1FF0)});
    endtask

    task automatic t_bad_opcode;
        nlog = 0;
        @(negedge clk);
        opcode = 6'd32; first_reg = 5'd20; base_field = 5'd0; disp = 16'h0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R2", "busy after illegal opcode", 64'(busy), 64'd0);
        repeat (4) @(negedge clk);
        chk("R2", "no request for illegal opcode", 64'(nlog), 64'd0);
        chk("R2", "still idle", 64'(busy), 64'd0);
    endtask

    task automatic t_stall_and_restart;
        stall_cfg = 2;
        for (int r = 30; r < 32; r++) regs[r] = {32'd0, 32'hC0DE_0000 + 32'(r)};
        run_op(6'd47, 5'd30, 5'd7, 64'h8000, 16'h0100, 1'b1);
        check_log("R8", 30, 64'h8100, 1'b1);
        chk("R2", "start while busy ignored", log_addr[1], 64'h8104);
        chk("R8", "stalled store data", 64'(log_wdata[1]), 64'(32'hC0DE_001F));
        stall_cfg = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_load_nonzero_base();
        t_store_zero_base();
        t_single_word_negative_disp();
        t_bad_opcode();
        t_stall_and_restart();
        $display("Result: errors=%0d of %0d checks", nerrors, nchecks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        nchecks++;
        nerrors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", nerrors, nchecks);
        $finish;
    end
endmodule